// File: doc/BRIEF.md
# Reactive Signal Port Unit

This unit gives a reactive processor direct access to pure binary signals. There is one 16-bit input port and one 16-bit output port, and each bit stands for a single presence-only signal. The control unit hands over each decoded reactive instruction as a valid strobe, a kind code and the 25-bit operand field. The unit then drives the output port, or it tests the synchronized input signals and reports back. No memory-mapped access is involved.

Emit and sustain copy a 16-bit signal mask from the operand field onto the output port, so any group of signals leaves in the same cycle. An emitted mask lasts one cycle. A sustained mask stays up until the next accepted reactive instruction or a preempt clear.

The tests work on a registered, synchronized copy of the input port. A polling wait stalls the core until one selected input is present. A presence test reports a taken branch in the same cycle. A conditional wait watches two inputs: the first one gives a fall-through and the second one gives a branch.

The wait state machine has three states:
- `ST_IDLE`: accepts instructions.
- `ST_POLL`: polling wait in progress.
- `ST_EITHER`: conditional wait in progress.

Its transitions are:
- `ST_IDLE` to `ST_POLL`: on a poll whose signal is absent.
- `ST_IDLE` to `ST_EITHER`: on a conditional wait with both signals absent.
- `ST_POLL` to `ST_IDLE`: when the selected signal is seen, or on a preempt clear.
- `ST_EITHER` to `ST_IDLE`: when either signal is seen, or on a preempt clear.

The output register has three modes:
- `OM_QUIET`: output is zero.
- `OM_PULSE`: a one-cycle emit is on the port.
- `OM_HELD`: a sustained mask is on the port.

Top module: `rsig_unit`

## Requirements
- R1: After reset, `sig_out` is 0, `hold` is 0 and `take_branch` is 0.
- R2: An accepted instruction with `op_kind`=1 (emit) places `op_field[24:9]` on `sig_out[15:0]` in the cycle after it is presented.
- R3: An emitted mask is on `sig_out` for exactly one cycle and then returns to 0. Any subset of bits, including all 16, can be emitted together.
- R4: An accepted instruction with `op_kind`=2 (sustain) places `op_field[24:9]` on `sig_out` from the next cycle on. The mask holds on every cycle until another accepted reactive instruction (kinds 1 to 5) replaces it.
- R5: `preempt_clr` drives `sig_out` to 0 in the following cycle and ends any wait. In the cycle it is high, `hold` and `take_branch` are 0 and `op_valid` is not accepted.
- R6: `sig_in` passes through two register stages before it is tested. A change presented before edge k is seen by the tests in the cycle after edge k+1 and not earlier.
- R7: A poll (`op_kind`=3) selects an input with `op_field[8:5]`. `hold` is 1 in every cycle in which that synchronized input is 0, starting with the cycle the poll is presented. `hold` drops in the first cycle the input is seen as 1.
- R8: While a wait is in progress, `op_valid` is ignored: an emit presented then does not reach `sig_out`.
- R9: A presence test (`op_kind`=4) selects an input with `op_field[8:5]`. In the same cycle it raises `take_branch` with `branch_addr` = `op_field[24:9]` if that input is present, and it raises nothing if the input is absent.
- R10: A conditional wait (`op_kind`=5) watches a first input selected by `op_field[8:5]` and a second one selected by `op_field[4:1]`. The first input present means fall-through with no branch, even when both are present. Only the second present means `take_branch` with `branch_addr` = `op_field[24:9]`. Neither present means `hold` until one of them appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | 16 | Asynchronous input signals |
| op_valid | input | 1 | A reactive instruction is presented this cycle |
| op_kind | input | 3 | 1 emit, 2 sustain, 3 poll, 4 presence test, 5 conditional wait |
| op_field | input | 25 | Operand field: mask/address [24:9], first select [8:5], second select [4:1] |
| preempt_clr | input | 1 | Preemption: clear outputs and cancel waits |
| sig_out | output | 16 | Output signal port |
| hold | output | 1 | Stall request to the control unit |
| take_branch | output | 1 | Branch to `branch_addr` |
| branch_addr | output | 16 | Branch target, valid with `take_branch` |

## Verification
Emit is tried with a sparse mask and with all sixteen bits. This shows exact bit mapping apart from pulse length. Sustain is followed in turn by idle cycles, by an emit and by a preempt clear, which tells replacement apart from clearing. Input-dependent operations are presented one cycle and then two cycles after an input change, which pins the synchronizer latency. The conditional wait is run three ways: both signals present, only the second present, and neither present followed by a late arrival. These runs separate the priority, branch and stall paths.

// File: rtl/rsig_pkg.sv
package rsig_pkg;
    typedef enum logic [2:0] {
        OPK_NONE    = 3'd0,
        OPK_EMIT    = 3'd1,
        OPK_SUSTAIN = 3'd2,
        OPK_POLL    = 3'd3,
        OPK_TEST    = 3'd4,
        OPK_EITHER  = 3'd5
    } opk_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_POLL   = 2'd1,
        ST_EITHER = 2'd2
    } wst_t;

    typedef enum logic [1:0] {
        OM_QUIET = 2'd0,
        OM_PULSE = 2'd1,
        OM_HELD  = 2'd2
    } omode_t;
endpackage

// File: rtl/rsig_sync.sv
module rsig_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= din;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/rsig_emit.sv
module rsig_emit
    import rsig_pkg::*;
#(
    parameter int NSIG = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            accept,
    input  opk_t            kind,
    input  logic [NSIG-1:0] mask,
    output logic [NSIG-1:0] sig_out
);
    omode_t          mode_q, mode_d;
    logic [NSIG-1:0] out_q, out_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= OM_QUIET;
            out_q  <= '0;
        end else begin
            mode_q <= mode_d;
            out_q  <= out_d;
        end
    end

    always_comb begin
        mode_d = mode_q;
        out_d  = out_q;
        if (clr) begin
            mode_d = OM_QUIET;
            out_d  = '0;
        end else if (accept && kind inside {OPK_EMIT, OPK_SUSTAIN, OPK_POLL, OPK_TEST, OPK_EITHER}) begin
            unique case (kind)
                OPK_EMIT: begin
                    mode_d = OM_PULSE;
                    out_d  = mask;
                end
                OPK_SUSTAIN: begin
                    mode_d = OM_HELD;
                    out_d  = mask;
                end
                default: begin
                    mode_d = OM_QUIET;
                    out_d  = '0;
                end
            endcase
        end else begin
            unique case (mode_q)
                OM_HELD: begin
                    mode_d = OM_HELD;
                    out_d  = out_q;
                end
                default: begin
                    mode_d = OM_QUIET;
                    out_d  = '0;
                end
            endcase
        end
    end

    assign sig_out = out_q;

    AST_EMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind == OPK_EMIT && !clr) |=> sig_out == $past(mask)); // R2
    AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind == OPK_EMIT && !clr) ##1 (!accept && !clr) |=> sig_out == '0); // R3
    AST_SUSTAIN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == OM_HELD && !accept && !clr) |=> $stable(sig_out)); // R4
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> sig_out == '0); // R5
endmodule

// File: rtl/rsig_wait.sv
module rsig_wait
    import rsig_pkg::*;
#(
    parameter int NSIG  = 16,
    parameter int ADDRW = 16,
    localparam int SELW = $clog2(NSIG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             op_valid,
    input  opk_t             kind,
    input  logic [SELW-1:0]  sel_a,
    input  logic [SELW-1:0]  sel_b,
    input  logic [ADDRW-1:0] addr,
    input  logic [NSIG-1:0]  sir,
    output logic             hold,
    output logic             take,
    output logic [ADDRW-1:0] br_addr,
    output logic             idle
);
    wst_t             st_q, st_d;
    logic [SELW-1:0]  sel_a_q, sel_b_q;
    logic [ADDRW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            sel_a_q <= '0;
            sel_b_q <= '0;
            addr_q  <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE) begin
                sel_a_q <= sel_a;
                sel_b_q <= sel_b;
                addr_q  <= addr;
            end
        end
    end

    always_comb begin
        st_d    = st_q;
        hold    = 1'b0;
        take    = 1'b0;
        br_addr = (st_q == ST_IDLE) ? addr : addr_q;
        unique case (st_q)
            ST_IDLE: begin
                if (op_valid && !clr) begin
                    if (kind == OPK_POLL) begin
                        if (!sir[sel_a]) begin
                            hold = 1'b1;
                            st_d = ST_POLL;
                        end
                    end else if (kind == OPK_TEST) begin
                        take = sir[sel_a];
                    end else if (kind == OPK_EITHER) begin
                        if (sir[sel_a]) begin
                            take = 1'b0;
                        end else if (sir[sel_b]) begin
                            take = 1'b1;
                        end else begin
                            hold = 1'b1;
                            st_d = ST_EITHER;
                        end
                    end
                end
            end
            ST_POLL: begin
                if (clr || sir[sel_a_q]) st_d = ST_IDLE;
                else                     hold = 1'b1;
            end
            ST_EITHER: begin
                if (clr || sir[sel_a_q]) begin
                    st_d = ST_IDLE;
                end else if (sir[sel_b_q]) begin
                    take = 1'b1;
                    st_d = ST_IDLE;
                end else begin
                    hold = 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign idle = (st_q == ST_IDLE);

    AST_HOLD_OR_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold && take)); // R10
    AST_HOLD_ENTERS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !idle); // R7
    AST_CLR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> idle); // R5
    AST_WAIT_STABLE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !$past(idle)) |-> $stable(addr_q)); // R8
endmodule

// File: rtl/rsig_unit.sv
module rsig_unit
    import rsig_pkg::*;
#(
    parameter int NSIG   = 16,
    parameter int ADDRW  = 16,
    parameter int FIELDW = 25,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSIG-1:0]   sig_in,
    input  logic              op_valid,
    input  logic [2:0]        op_kind,
    input  logic [FIELDW-1:0] op_field,
    input  logic              preempt_clr,
    output logic [NSIG-1:0]   sig_out,
    output logic              hold,
    output logic              take_branch,
    output logic [ADDRW-1:0]  branch_addr
);
    localparam int SELW   = $clog2(NSIG);
    localparam int MASK_LO = FIELDW - NSIG;
    localparam int SA_LO  = MASK_LO - SELW;
    localparam int SB_LO  = SA_LO - SELW;

    opk_t             kind;
    logic [NSIG-1:0]  sir;
    logic             idle;
    logic             accept;

    assign kind   = opk_t'(op_kind);
    assign accept = op_valid && idle && !preempt_clr;

    rsig_sync #(.W(NSIG), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sig_in),
        .dout (sir)
    );

    rsig_emit #(.NSIG(NSIG)) u_emit (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (preempt_clr),
        .accept (accept),
        .kind   (kind),
        .mask   (op_field[FIELDW-1:MASK_LO]),
        .sig_out(sig_out)
    );

    rsig_wait #(.NSIG(NSIG), .ADDRW(ADDRW)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (preempt_clr),
        .op_valid(op_valid),
        .kind    (kind),
        .sel_a   (op_field[SA_LO +: SELW]),
        .sel_b   (op_field[SB_LO +: SELW]),
        .addr    (op_field[FIELDW-1 -: ADDRW]),
        .sir     (sir),
        .hold    (hold),
        .take    (take_branch),
        .br_addr (branch_addr),
        .idle    (idle)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (sig_out == '0 && !hold)); // R1
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && op_valid && kind == OPK_EMIT && !preempt_clr && $past(sig_out) == '0 && sig_out == '0) |=> sig_out == '0); // R8
endmodule

// File: tb/sim_rsig_unit.sv
module sim_rsig_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] sig_in = '0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_kind = '0;
    logic [24:0] op_field = '0;
    logic        preempt_clr = 1'b0;
    logic [15:0] sig_out;
    logic        hold;
    logic        take_branch;
    logic [15:0] branch_addr;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    int          q_cyc[$];
    int          q_what[$];
    logic [15:0] q_val[$];
    string       q_req[$];

    localparam int W_OUT = 0, W_HOLD = 1, W_TAKE = 2, W_ADDR = 3;

    rsig_unit u0 (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .op_valid(op_valid),
        .op_kind(op_kind), .op_field(op_field), .preempt_clr(preempt_clr),
        .sig_out(sig_out), .hold(hold), .take_branch(take_branch),
        .branch_addr(branch_addr)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [24:0] mk(input logic [15:0] m, input logic [3:0] a, input logic [3:0] b);
        return {m, a, b, 1'b0};
    endfunction

    task automatic expect_at(input int c, input int what, input logic [15:0] v, input string req);
        int pos = q_cyc.size();
        while (pos > 0 && q_cyc[pos-1] > c) pos--;
        q_cyc.insert(pos, c);
        q_what.insert(pos, what);
        q_val.insert(pos, v);
        q_req.insert(pos, req);
    endtask

    task automatic drive(input logic v, input logic [2:0] k, input logic [24:0] f,
                         input logic clr, input logic [15:0] din);
        @(negedge clk);
        op_valid = v; op_kind = k; op_field = f; preempt_clr = clr; sig_in = din;
    endtask

    task automatic idle_cyc(input logic [15:0] din);
        drive(1'b0, 3'd0, '0, 1'b0, din);
    endtask

    always @(negedge clk) begin
        #1;
        while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
            logic [15:0] act;
            unique case (q_what[0])
                W_OUT:  act = sig_out;
                W_HOLD: act = {15'd0, hold};
                W_TAKE: act = {15'd0, take_branch};
                default: act = branch_addr;
            endcase
            n_chk++;
            if (act !== q_val[0]) begin
                n_bad++;
                $display("FAIL %s cycle %0d item %0d: actual %h expected %h",
                         q_req[0], cyc, q_what[0], act, q_val[0]);
            end
            void'(q_cyc.pop_front()); void'(q_what.pop_front());
            void'(q_val.pop_front()); void'(q_req.pop_front());
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] din = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        idle_cyc(din);
        expect_at(cyc, W_OUT, 16'h0, "R1"); expect_at(cyc, W_HOLD, 0, "R1"); expect_at(cyc, W_TAKE, 0, "R1");
        // R2/R3 emit sparse and full
        drive(1, 3'd1, mk(16'hA5C3, 0, 0), 0, din); expect_at(cyc+1, W_OUT, 16'hA5C3, "R2");
        idle_cyc(din); expect_at(cyc+1, W_OUT, 16'h0, "R3");
        drive(1, 3'd1, mk(16'hFFFF, 0, 0), 0, din); expect_at(cyc+1, W_OUT, 16'hFFFF, "R3");
        idle_cyc(din); expect_at(cyc+1, W_OUT, 16'h0, "R3");
        // R4 sustain then replace
        drive(1, 3'd2, mk(16'h0101, 0, 0), 0, din); expect_at(cyc+1, W_OUT, 16'h0101, "R4");
        for (int i = 0; i < 3; i++) begin
            idle_cyc(din); expect_at(cyc+1, W_OUT, 16'h0101, "R4");
        end
        drive(1, 3'd1, mk(16'h0002, 0, 0), 0, din); expect_at(cyc+1, W_OUT, 16'h0002, "R4");
        idle_cyc(din); expect_at(cyc+1, W_OUT, 16'h0, "R3");
        // R5 sustain cleared by preemption
        drive(1, 3'd2, mk(16'h8000, 0, 0), 0, din); expect_at(cyc+1, W_OUT, 16'h8000, "R4");
        drive(0, 3'd0, '0, 1, din); expect_at(cyc+1, W_OUT, 16'h0, "R5");
        idle_cyc(din); expect_at(cyc+1, W_OUT, 16'h0, "R5");
        // R6 synchronizer latency through presence test
        din = 16'h0008;
        idle_cyc(din);
        drive(1, 3'd4, mk(16'h1357, 3, 0), 0, din); expect_at(cyc, W_TAKE, 0, "R6");
        drive(1, 3'd4, mk(16'h1357, 3, 0), 0, din); expect_at(cyc, W_TAKE, 1, "R6");
        expect_at(cyc, W_ADDR, 16'h1357, "R9");
        drive(1, 3'd4, mk(16'h1357, 6, 0), 0, din); expect_at(cyc, W_TAKE, 0, "R9"); expect_at(cyc, W_HOLD, 0, "R9");
        // R7 poll: present at once, then absent with late arrival
        drive(1, 3'd3, mk(16'h0, 3, 0), 0, din); expect_at(cyc, W_HOLD, 0, "R7");
        drive(1, 3'd3, mk(16'h0, 2, 0), 0, din); expect_at(cyc, W_HOLD, 1, "R7");
        drive(1, 3'd1, mk(16'h00FF, 0, 0), 0, din); expect_at(cyc, W_HOLD, 1, "R7");
        expect_at(cyc+1, W_OUT, 16'h0, "R8");
        din = 16'h0004;
        idle_cyc(din); expect_at(cyc, W_HOLD, 1, "R7");
        idle_cyc(din); expect_at(cyc, W_HOLD, 1, "R6");
        idle_cyc(din); expect_at(cyc, W_HOLD, 0, "R7");
        idle_cyc(din); expect_at(cyc, W_HOLD, 0, "R7"); expect_at(cyc, W_OUT, 16'h0, "R8");
        // R10 conditional wait
        din = 16'h0084;
        idle_cyc(din); idle_cyc(din);
        drive(1, 3'd5, mk(16'h2222, 2, 7), 0, din);
        expect_at(cyc, W_TAKE, 0, "R10"); expect_at(cyc, W_HOLD, 0, "R10");
        drive(1, 3'd5, mk(16'h3333, 9, 7), 0, din);
        expect_at(cyc, W_TAKE, 1, "R10"); expect_at(cyc, W_ADDR, 16'h3333, "R10"); expect_at(cyc, W_HOLD, 0, "R10");
        drive(1, 3'd5, mk(16'h1234, 9, 11), 0, din); expect_at(cyc, W_HOLD, 1, "R10"); expect_at(cyc, W_TAKE, 0, "R10");
        din = 16'h0880;
        idle_cyc(din); expect_at(cyc, W_HOLD, 1, "R10");
        idle_cyc(din); expect_at(cyc, W_HOLD, 1, "R10");
        idle_cyc(din); expect_at(cyc, W_TAKE, 1, "R10"); expect_at(cyc, W_ADDR, 16'h1234, "R10");
        expect_at(cyc, W_HOLD, 0, "R10");
        idle_cyc(din); expect_at(cyc, W_TAKE, 0, "R10");
        // R5 preemption cancels a wait
        drive(1, 3'd3, mk(16'h0, 0, 0), 0, din); expect_at(cyc, W_HOLD, 1, "R7");
        drive(0, 3'd0, '0, 1, din); expect_at(cyc, W_HOLD, 0, "R5");
        idle_cyc(din); expect_at(cyc, W_HOLD, 0, "R5");
        repeat (3) idle_cyc(din);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule